// File: doc/BRIEF.md
# Four-Wire Serial Display Command Engine

This block runs single transactions on a serial display link with a separate data/command select line. Each transaction is either a command write or a register read. A write shifts one command byte with the select line low and then any parameter bytes with the line high. A read shifts the command byte and then clocks in the requested number of response bytes. The serial clock rate is derived from the system clock by integer half-period counts. These counts are computed at elaboration from the system frequency and the link's maximum frequency. The rate depends on the phase and the transfer length.

Parameter bytes are not stored inside the block. The engine presents an index on `par_addr` and takes the value from `par_data` in the same cycle, so a frame buffer or a small table can sit outside it. The identification read and the status read answer one clock late. For these two, the engine receives one extra byte and shifts the result left by one bit. A completed power-mode read also updates a display-on indication.

Top module: `disp_cmd_engine`

## Requirements
- R1: A transaction holds `cs_n` low from the first bit to the last. SCK idles low (mode 0). `mosi` and `dc` change only while SCK is low, and bytes go out MSB first. `dc` is 0 for the command byte and 1 for every parameter byte of a write.
- R2: A write with `len` = 0 drops `cs_n`, produces exactly 8 SCK pulses for the command byte and then completes.
- R3: The command byte of a write, and a parameter phase of 64 bytes or fewer, run at a half-period of ceil(SYS_HZ / (2·min(10 MHz, MAX_HZ))) system cycles. A parameter phase longer than 64 bytes runs at ceil(SYS_HZ / (2·MAX_HZ)). With the defaults these are 13 and 3 cycles.
- R4: A read runs entirely at a half-period of ceil(SYS_HZ / (2·min(2 MHz, MAX_HZ/2))) cycles, which is 63 with the defaults. `dc` stays 0 throughout. The command byte is followed by `len` response bytes sampled on the rising SCK edge, MSB first. Response byte i appears in `rd_data[8i+7:8i]`.
- R5: For reads of opcode 0x04 (identification) and 0x09 (status), len+1 bytes are clocked in. Result byte i equals (raw[i] << 1) | raw[i+1][7].
- R6: A read with `len` = 0, with `len` greater than RD_MAX (4), or of opcode 0x04 or 0x09 with a length other than 3 or 4, is rejected. `done` and `err` are then high in the cycle after `start`. `cs_n` never drops, and `rd_data` keeps its value.
- R7: For a write of opcode 0x2C with `swap` = 0, `par_addr` is a 16-bit word index. Each word goes out as `par_data[15:8]` and then `par_data[7:0]`. Every other write, and opcode 0x2C with `swap` = 1, uses `par_addr` as a byte index and sends `par_data[7:0]`.
- R8: Each successful read updates `disp_on`. It becomes 1 only for opcode 0x0A with `len` = 1 when (byte0 & 0x7C) == 0x1C, and becomes 0 for any other read.
- R9: `done` is a one-cycle pulse, coincident with `cs_n` rising on a completed transfer. `err` is high only together with `done`. A `start` received while a transaction is in progress is ignored. After reset, `cs_n` = 1, SCK = 0, and `done`, `err` and `disp_on` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction when idle |
| is_read | input | 1 | 1 = register read, 0 = command write |
| op | input | 8 | Command byte |
| len | input | LEN_W | Parameter byte count (write) or response byte count (read) |
| swap | input | 1 | Send memory-write data byte by byte instead of as words |
| par_addr | output | LEN_W | Index of the parameter byte or word being fetched |
| par_data | input | 16 | Parameter value for `par_addr`, valid in the same cycle |
| rd_data | output | 8·RD_MAX | Read result, byte i at bits [8i+7:8i] |
| done | output | 1 | Completion pulse |
| err | output | 1 | Rejected request, with `done` |
| disp_on | output | 1 | Last power-mode read showed the display on |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| dc | output | 1 | Data (1) or command (0) select |
| miso | input | 1 | Serial data in |

## Verification
Two situations are the hardest to reach from the ports. One is the one-bit realignment of the identification and status reads. The other is the rate change at the 64-byte limit. For the first, the bench's serial responder places a random dummy bit ahead of known bytes and appends random filler. A wrong realignment therefore shows up as a shifted result or a wrong bit count. For the second, the bench measures every SCK half-period and classifies it by the `dc` level at its start. Writes of exactly 64 and 65 bytes then expose an off-by-one in the length comparison or a late rate switch at the command-to-parameter boundary.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_PAR,
        S_RESP,
        S_FIN
    } eng_state_e;

    typedef enum logic [1:0] {
        RATE_CMD,
        RATE_FAST,
        RATE_READ
    } rate_e;

    localparam logic [7:0] OP_MEM_WRITE  = 8'h2C;
    localparam logic [7:0] OP_GET_ID     = 8'h04;
    localparam logic [7:0] OP_GET_STATUS = 8'h09;
    localparam logic [7:0] OP_GET_POWER  = 8'h0A;
    localparam logic [7:0] POWER_MASK    = 8'h7C;
    localparam logic [7:0] POWER_ON_VAL  = 8'h1C;

    // Half-period in system cycles, rounded up so the rate never exceeds rate_hz.
    function automatic int half_cycles(int sys_hz, int rate_hz);
        return (sys_hz + 2 * rate_hz - 1) / (2 * rate_hz);
    endfunction

    function automatic int min_int(int a, int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/disp_sck_gen.sv
module disp_sck_gen
    import disp_cmd_pkg::*;
#(
    parameter int HALF_CMD  = 13,
    parameter int HALF_FAST = 3,
    parameter int HALF_READ = 63
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  rate_e rate,
    output logic  tick
);
    localparam int HMAX = (HALF_READ > HALF_CMD) ?
                          ((HALF_READ > HALF_FAST) ? HALF_READ : HALF_FAST) :
                          ((HALF_CMD > HALF_FAST) ? HALF_CMD : HALF_FAST);
    localparam int CW = $clog2(HMAX + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] half_sel;

    always_comb begin
        case (rate)
            RATE_FAST: half_sel = CW'(HALF_FAST);
            RATE_READ: half_sel = CW'(HALF_READ);
            default:   half_sel = CW'(HALF_CMD);
        endcase
        tick  = run && (cnt_q == half_sel - CW'(1));
        cnt_d = (!run || tick) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/disp_rx_align.sv
module disp_rx_align #(
    parameter int RD_MAX = 4,
    parameter int LEN_W  = 16
) (
    input  logic [(RD_MAX+1)*8-1:0] raw,
    input  logic [LEN_W-1:0]        len,
    input  logic                    dummy,
    output logic [RD_MAX*8-1:0]     data
);
    generate
        for (genvar i = 0; i < RD_MAX; i++) begin : g_byte
            logic [7:0] shifted;
            assign shifted = {raw[8*i +: 7], raw[8*(i+1) + 7]};
            assign data[8*i +: 8] = (len > LEN_W'(i)) ?
                                    (dummy ? shifted : raw[8*i +: 8]) : 8'h00;
        end
    endgenerate
endmodule

// File: rtl/disp_cmd_engine.sv
module disp_cmd_engine
    import disp_cmd_pkg::*;
#(
    parameter int SYS_HZ        = 250_000_000,
    parameter int MAX_HZ        = 50_000_000,
    parameter int CMD_HZ_CAP    = 10_000_000,
    parameter int READ_HZ_CAP   = 2_000_000,
    parameter int SLOW_LEN_MAX  = 64,
    parameter int LEN_W         = 16,
    parameter int RD_MAX        = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  is_read,
    input  logic [7:0]            op,
    input  logic [LEN_W-1:0]      len,
    input  logic                  swap,
    output logic [LEN_W-1:0]      par_addr,
    input  logic [15:0]           par_data,
    output logic [RD_MAX*8-1:0]   rd_data,
    output logic                  done,
    output logic                  err,
    output logic                  disp_on,
    output logic                  cs_n,
    output logic                  sck,
    output logic                  mosi,
    output logic                  dc,
    input  logic                  miso
);
    localparam int CMD_HZ    = min_int(CMD_HZ_CAP, MAX_HZ);
    localparam int READ_HZ   = min_int(READ_HZ_CAP, MAX_HZ / 2);
    localparam int HALF_CMD  = half_cycles(SYS_HZ, CMD_HZ);
    localparam int HALF_FAST = half_cycles(SYS_HZ, MAX_HZ);
    localparam int HALF_READ = half_cycles(SYS_HZ, READ_HZ);
    localparam int RAW_W     = (RD_MAX + 1) * 8;
    localparam int RDW       = RD_MAX * 8;

    typedef struct packed {
        eng_state_e       st;
        rate_e            rate;
        logic             cs_n;
        logic             sck;
        logic             mosi;
        logic             dc;
        logic [7:0]       tx;
        logic [7:0]       rx;
        logic [2:0]       bit_n;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] nbytes;
        logic             rd;
        logic             dummy;
        logic             wmode;
        logic             big;
        logic [RAW_W-1:0] raw;
        logic [RDW-1:0]   rdata;
        logic             on;
        logic             done;
        logic             err;
        logic [7:0]       op;
    } eng_t;

    eng_t q, d;
    logic tick;
    logic [RDW-1:0] aligned;
    logic [7:0] next_byte;
    logic [7:0] rx_byte;
    logic dummy_op;
    logic reject;

    disp_sck_gen #(
        .HALF_CMD (HALF_CMD),
        .HALF_FAST(HALF_FAST),
        .HALF_READ(HALF_READ)
    ) u_sck (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.st != S_IDLE),
        .rate (q.rate),
        .tick (tick)
    );

    disp_rx_align #(
        .RD_MAX(RD_MAX),
        .LEN_W (LEN_W)
    ) u_align (
        .raw  (q.raw),
        .len  (q.len),
        .dummy(q.dummy),
        .data (aligned)
    );

    // Parameter fetch: word index in word mode, byte index otherwise.
    assign par_addr  = q.wmode ? (q.cnt >> 1) : q.cnt;
    assign next_byte = (q.wmode && !q.cnt[0]) ? par_data[15:8] : par_data[7:0];
    assign rx_byte   = {q.rx[6:0], miso};

    assign dummy_op = (op == OP_GET_ID) || (op == OP_GET_STATUS);
    assign reject   = is_read && ((len == '0) || (len > LEN_W'(RD_MAX)) ||
                      (dummy_op && (len != LEN_W'(3)) && (len != LEN_W'(4))));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    if (reject) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.st     = S_CMD;
                        d.cs_n   = 1'b0;
                        d.dc     = 1'b0;
                        d.sck    = 1'b0;
                        d.tx     = op;
                        d.mosi   = op[7];
                        d.bit_n  = '0;
                        d.cnt    = '0;
                        d.len    = len;
                        d.rd     = is_read;
                        d.dummy  = is_read && dummy_op;
                        d.wmode  = !is_read && (op == OP_MEM_WRITE) && !swap;
                        d.big    = len > LEN_W'(SLOW_LEN_MAX);
                        d.rate   = is_read ? RATE_READ : RATE_CMD;
                        d.nbytes = (is_read && dummy_op) ? len + LEN_W'(1) : len;
                        d.op     = op;
                        d.raw    = '0;
                        d.rx     = '0;
                    end
                end
            end
            S_CMD, S_PAR, S_RESP: begin
                if (tick) begin
                    if (!q.sck) begin
                        d.sck = 1'b1;
                        if (q.st == S_RESP) begin
                            d.rx = rx_byte;
                            if (q.bit_n == 3'd7) begin
                                for (int j = 0; j < RD_MAX + 1; j++) begin
                                    if (q.cnt == LEN_W'(j)) d.raw[8*j +: 8] = rx_byte;
                                end
                            end
                        end
                    end else begin
                        d.sck = 1'b0;
                        if (q.bit_n != 3'd7) begin
                            d.bit_n = q.bit_n + 3'd1;
                            d.tx    = {q.tx[6:0], 1'b0};
                            d.mosi  = q.tx[6];
                        end else begin
                            d.bit_n = '0;
                            case (q.st)
                                S_CMD: begin
                                    if (q.rd) begin
                                        d.st   = S_RESP;
                                        d.mosi = 1'b0;
                                        d.cnt  = '0;
                                    end else if (q.len == '0) begin
                                        d.st   = S_FIN;
                                        d.mosi = 1'b0;
                                    end else begin
                                        d.st   = S_PAR;
                                        d.dc   = 1'b1;
                                        d.tx   = next_byte;
                                        d.mosi = next_byte[7];
                                        d.cnt  = q.cnt + LEN_W'(1);
                                        d.rate = q.big ? RATE_FAST : RATE_CMD;
                                    end
                                end
                                S_PAR: begin
                                    if (q.cnt == q.len) begin
                                        d.st   = S_FIN;
                                        d.mosi = 1'b0;
                                    end else begin
                                        d.tx   = next_byte;
                                        d.mosi = next_byte[7];
                                        d.cnt  = q.cnt + LEN_W'(1);
                                    end
                                end
                                default: begin
                                    if (q.cnt + LEN_W'(1) == q.nbytes) d.st = S_FIN;
                                    else d.cnt = q.cnt + LEN_W'(1);
                                end
                            endcase
                        end
                    end
                end
            end
            S_FIN: begin
                if (tick) begin
                    d.st   = S_IDLE;
                    d.cs_n = 1'b1;
                    d.dc   = 1'b0;
                    d.mosi = 1'b0;
                    d.done = 1'b1;
                    if (q.rd) begin
                        d.rdata = aligned;
                        d.on    = (q.op == OP_GET_POWER) && (q.len == LEN_W'(1)) &&
                                  ((aligned[7:0] & POWER_MASK) == POWER_ON_VAL);
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.rate <= RATE_CMD;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_data = q.rdata;
    assign done    = q.done;
    assign err     = q.err;
    assign disp_on = q.on;
    assign cs_n    = q.cs_n;
    assign sck     = q.sck;
    assign mosi    = q.mosi;
    assign dc      = q.dc;

endmodule

// File: rtl/disp_cmd_chk.sv
module disp_cmd_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic mosi,
    input logic dc,
    input logic done,
    input logic err
);
    assert_sck_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    assert_mode0_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sck && $past(sck)) |-> ($stable(mosi) && $stable(dc)));

    assert_cmd_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !dc);

    assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && cs_n && $past(cs_n)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_release_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);
endmodule

bind disp_cmd_engine disp_cmd_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (cs_n),
    .sck  (sck),
    .mosi (mosi),
    .dc   (dc),
    .done (done),
    .err  (err)
);

// File: tb/sim_disp_cmd_engine.sv
`timescale 1ns/1ps
module sim_disp_cmd_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        start = 1'b0, is_read = 1'b0, swap = 1'b0;
    logic [7:0]  op = 8'h00;
    logic [15:0] len = 16'd0;
    logic [15:0] par_addr, par_data;
    logic [31:0] rd_data;
    logic        done, err, disp_on, cs_n, sck, mosi, dc, miso;

    int unsigned salt = 0;
    int n_chk = 0, n_fail = 0;

    function automatic logic [15:0] word_at(int a, int unsigned s);
        return 16'((a * 40503 + int'(s) * 977 + 7) ^ (a >> 3));
    endfunction

    always_comb par_data = word_at(int'(par_addr), salt);

    disp_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read), .op(op),
        .len(len), .swap(swap), .par_addr(par_addr), .par_data(par_data),
        .rd_data(rd_data), .done(done), .err(err), .disp_on(disp_on),
        .cs_n(cs_n), .sck(sck), .mosi(mosi), .dc(dc), .miso(miso)
    );

    // Serial monitor and responder
    int   cyc = 0, last_edge = -1, rise_cnt = 0, iv_bad = 0;
    int   cs_falls = 0, done_cnt = 0;
    int   exp_cmd_h = 13, exp_par_h = 13;
    logic last_dc = 1'b0, p_sck = 1'b0, p_cs = 1'b1;
    logic cap_b  [0:1023];
    logic cap_dc [0:1023];
    logic [63:0] resp = '0;

    assign miso = (rise_cnt >= 8 && rise_cnt < 72) ? resp[6'(rise_cnt - 8)] : 1'b0;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (done) done_cnt++;
        if (p_cs && !cs_n) begin
            cs_falls++;
            rise_cnt  = 0;
            last_edge = -1;
        end
        if (!cs_n && sck !== p_sck) begin
            if (last_edge >= 0) begin
                if ((cyc - last_edge) != (last_dc ? exp_par_h : exp_cmd_h)) iv_bad++;
            end
            last_edge = cyc;
            last_dc   = dc;
            if (sck && rise_cnt < 1024) begin
                cap_b[rise_cnt]  = mosi;
                cap_dc[rise_cnt] = dc;
                rise_cnt++;
            end
        end
        p_sck = sck;
        p_cs  = cs_n;
        if (cyc == 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog actual=%0d expected=<190000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [7:0] cap_byte(int k);
        logic [7:0] v;
        for (int b = 0; b < 8; b++) v[7-b] = cap_b[8*k + b];
        return v;
    endfunction

    task automatic go(logic rd, logic [7:0] c, int n, logic sw);
        @(negedge clk);
        is_read = rd; op = c; len = 16'(n); swap = sw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen, output bit e);
        seen = 0; e = 0;
        for (int i = 0; i < 20000; i++) begin
            if (done) begin seen = 1; e = err; break; end
            @(negedge clk);
        end
    endtask

    task automatic do_write(logic [7:0] c, int n, logic sw, bit intr, string tag);
        bit seen, e;
        int d0, c0, bad, dcbad;
        bit wm;
        logic [15:0] wd;
        logic [7:0] eb;
        salt = $urandom;
        exp_cmd_h = 13;
        exp_par_h = (n > 64) ? 3 : 13;
        iv_bad = 0; d0 = done_cnt; c0 = cs_falls;
        go(1'b0, c, n, sw);
        if (intr) begin
            repeat (60) @(negedge clk);
            op = 8'h55; len = 16'd9; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(seen, e);
        repeat (40) @(negedge clk);
        chk(seen && !e, {tag, " completion"}, {seen, e}, 2'b10);
        chk(rise_cnt == 8 * (n + 1), {tag, " R1 R2 bit count"}, rise_cnt, 8 * (n + 1));
        bad = 0; dcbad = 0;
        wm = (c == 8'h2C) && !sw;
        if (cap_byte(0) != c) bad++;
        for (int b = 0; b < 8; b++) if (cap_dc[b] !== 1'b0) dcbad++;
        for (int k = 0; k < n; k++) begin
            wd = word_at(wm ? k / 2 : k, salt);
            eb = wm ? ((k % 2 == 0) ? wd[15:8] : wd[7:0]) : wd[7:0];
            if (cap_byte(k + 1) != eb) bad++;
            for (int b = 0; b < 8; b++) if (cap_dc[8*(k+1) + b] !== 1'b1) dcbad++;
        end
        chk(bad == 0, {tag, " R1 R7 byte values"}, bad, 0);
        chk(dcbad == 0, {tag, " R1 dc level"}, dcbad, 0);
        chk(iv_bad == 0, {tag, " R3 sck half-period"}, iv_bad, 0);
        chk(done_cnt - d0 == 1 && cs_falls - c0 == 1, {tag, " R9 single transaction"},
            (done_cnt - d0) * 16 + (cs_falls - c0), 17);
    endtask

    task automatic do_read(logic [7:0] c, int n, logic [31:0] data, string tag);
        bit seen, e, dm;
        int nb, p;
        logic [31:0] mask;
        dm = (c == 8'h04) || (c == 8'h09);
        resp = {$urandom, $urandom};
        for (int i = 0; i < n; i++)
            for (int b = 7; b >= 0; b--) begin
                p = 8 * i + (7 - b) + (dm ? 1 : 0);
                resp[p] = data[8*i + b];
            end
        nb = n + (dm ? 1 : 0);
        exp_cmd_h = 63; exp_par_h = 63; iv_bad = 0;
        go(1'b1, c, n, 1'b0);
        wait_done(seen, e);
        repeat (3) @(negedge clk);
        mask = (n >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * n)) - 32'd1);
        chk(seen && !e, {tag, " completion"}, {seen, e}, 2'b10);
        chk((rd_data & mask) == (data & mask), {tag, " R4 R5 read data"}, rd_data & mask, data & mask);
        chk(rise_cnt == 8 * (1 + nb), {tag, " R4 R5 bit count"}, rise_cnt, 8 * (1 + nb));
        chk(cap_byte(0) == c && cap_dc[0] == 1'b0 && dc == 1'b0, {tag, " R4 command byte"}, cap_byte(0), c);
        chk(iv_bad == 0, {tag, " R4 read half-period"}, iv_bad, 0);
    endtask

    task automatic do_bad(logic [7:0] c, int n);
        int c0;
        logic [31:0] prev;
        c0 = cs_falls; prev = rd_data;
        @(negedge clk);
        is_read = 1'b1; op = c; len = 16'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && err, "R6 reject flags", {done, err}, 2'b11);
        repeat (3) @(negedge clk);
        chk(cs_falls == c0 && rd_data == prev && !done, "R6 no bus activity", cs_falls - c0, 0);
    endtask

    initial begin
        logic [31:0] r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !sck && !done && !err && !disp_on, "R9 reset state",
            {cs_n, sck, done, err, disp_on}, 5'b10000);

        do_write(8'h11, 0, 1'b0, 1'b0, "R2 zero-param");
        do_write(8'h36, 1, 1'b0, 1'b0, "R1 one-param");
        do_write(8'h2A, 4, 1'b0, 1'b0, "R1 four-param");
        do_write(8'h2C, 6, 1'b0, 1'b0, "R7 word mode");
        do_write(8'h2C, 7, 1'b0, 1'b0, "R7 word mode odd");
        do_write(8'h2C, 5, 1'b1, 1'b0, "R7 swap byte mode");
        do_write(8'h2B, 64, 1'b0, 1'b0, "R3 64-byte slow");
        do_write(8'h2C, 65, 1'b0, 1'b0, "R3 65-byte fast");
        for (int i = 0; i < 6; i++)
            do_write(8'($urandom), int'($urandom % 9), 1'($urandom), 1'b0, "R1 random");
        do_write(8'h3A, 3, 1'b0, 1'b1, "R9 start while busy");

        do_read(8'h0A, 1, 32'h9F, "R8 power 9F");
        chk(disp_on == 1'b1, "R8 display on 9F", disp_on, 1);
        do_read(8'h0A, 1, 32'h08, "R8 power 08");
        chk(disp_on == 1'b0, "R8 display off 08", disp_on, 0);
        do_read(8'h0A, 1, 32'h1D, "R8 power 1D");
        chk(disp_on == 1'b1, "R8 display on 1D", disp_on, 1);
        do_read(8'h0C, 1, 32'h1C, "R8 other read");
        chk(disp_on == 1'b0, "R8 cleared by other read", disp_on, 0);
        do_read(8'h0A, 1, 32'h5F, "R8 power 5F");
        chk(disp_on == 1'b0, "R8 display off 5F", disp_on, 0);

        r = $urandom;
        do_read(8'h04, 3, r & 32'h00FF_FFFF, "R5 id read");
        r = $urandom;
        do_read(8'h09, 4, r, "R5 status read");
        r = $urandom;
        do_read(8'h0B, 2, r & 32'h0000_FFFF, "R4 two-byte read");
        r = $urandom;
        do_read(8'h0D, 4, r, "R4 four-byte read");

        do_bad(8'h0A, 0);
        do_bad(8'h04, 2);
        do_bad(8'h09, 5);
        do_bad(8'h0C, 5);
        do_bad(8'h04, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule